// File: doc/BRIEF.md
# Dual Clock Output Gate

This block sits between the clock sources of a small clock generator and its two output pins. The first output carries either the undivided master clock or the prescaled clock. The second output carries the divided clock. One control pin is tied to each output. Three configuration bits decide what the first control pin does: it can enable the output, select its frequency, or power the block down. A fourth bit decides whether the second control pin enables its output or powers the block down. The sources reach the block as level inputs that are synchronous to the master clock `clk`. Configuration arrives as a 4-bit register write.

An output enable only changes while the clock it gates is low, so no pulse is ever cut short. A power-down request must be held for `PD_MIN` cycles before it is accepted. The block then drains both outputs and enters the down state, where configuration writes are refused. When the request is released, both outputs stay dark for `STAB_CYCLES` cycles before they are enabled again. A control pin that is high requests disable or power-down, and a low pin requests enable. Both control pins pass through two-flop synchronizers.

Top module: `twin_clk_gate`

## Requirements
- R1: After reset the configuration is en0=1, sel0=1, pdn0=0, pdn1=0. A write drives `cfg_wdata[0]`=en0, `[1]`=sel0, `[2]`=pdn0 and `[3]`=pdn1. Once stabilization ends with both control pins low, out0 is enabled and carries `src_pre`, and out1 is enabled.
- R2: With pdn0=1, holding ctrl0 high powers the block down, whatever en0 and sel0 hold. With ctrl0 low, out0 is enabled and sel0 picks its source (0 selects `src_mst`, 1 selects `src_pre`).
- R3: With pdn0=0 and en0=1, ctrl0 is the output enable of out0 (high disables it) and sel0 picks its source.
- R4: With pdn0=0, en0=0 and sel0=1, ctrl0 picks the source of out0 (0 selects `src_mst`, 1 selects `src_pre`) and out0 stays enabled. The mux select changes only on an edge where both sources are low.
- R5: With en0, sel0 and pdn0 all 0, out0 is always disabled, and holding ctrl0 high powers the block down.
- R6: With pdn1=1, holding ctrl1 high powers the block down. With pdn1=0, ctrl1 high disables out1 only and leaves out0 enabled.
- R7: An output enable changes only on an edge where the source that output carries is low. An output that is disabled drives 0.
- R8: Power-down first disables both outputs, each waiting for its low phase. In the down state both enables are 0.
- R9: After reset, and after a power-down request is released, both enables stay 0 for at least `STAB_CYCLES` cycles.
- R10: Configuration writes made while the block is in the down state are ignored.
- R11: A power-down request held for fewer than `PD_MIN` consecutive cycles, counted after synchronization, is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all counting is in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_mst | input | 1 | Master clock level offered to out0 |
| src_pre | input | 1 | Prescaled clock level offered to out0 |
| src_div | input | 1 | Divided clock level carried by out1 |
| ctrl0 | input | 1 | Control pin for out0 (asynchronous) |
| ctrl1 | input | 1 | Control pin for out1 (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {pdn1, pdn0, sel0, en0} |
| out0 | output | 1 | Gated clock 0 |
| out0_oe | output | 1 | Drive enable of out0 (0 means high impedance) |
| out1 | output | 1 | Gated clock 1 |
| out1_oe | output | 1 | Drive enable of out1 (0 means high impedance) |

## Verification
The hardest case to reach from the ports is the write lock. A write only arrives while the block is down, and its effect can only be seen after the block has stabilized again. The bench holds ctrl1 high in its power-down role and, while down, writes a configuration that would turn ctrl1 into a plain output enable and switch out0 off. It then releases the pin, waits out stabilization, and probes with ctrl1 again to show that the old roles are still in place. The bench also sweeps all eight ctrl0 configurations with both pin levels and times the recovery window against `STAB_CYCLES`.

// File: rtl/twin_clk_gate.sv
module twin_clk_gate #(
  parameter int STAB_CYCLES = 8000,
  parameter int PD_MIN      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_mst,
  input  logic       src_pre,
  input  logic       src_div,
  input  logic       ctrl0,
  input  logic       ctrl1,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  output logic       out0,
  output logic       out0_oe,
  output logic       out1,
  output logic       out1_oe
);
  localparam int SW = $clog2(STAB_CYCLES + 1);
  localparam int PW = $clog2(PD_MIN + 1);

  typedef enum logic [1:0] {ST_STAB = 2'd0, ST_RUN = 2'd1, ST_DRAIN = 2'd2, ST_DOWN = 2'd3} pwr_t;

  pwr_t          st;
  logic [3:0]    cfg;
  logic [1:0]    c0_s, c1_s;
  logic [SW-1:0] stab_cnt;
  logic [PW-1:0] pd_cnt;
  logic          sel_q, oe0, oe1;

  wire c0  = c0_s[1];
  wire c1  = c1_s[1];
  wire en0 = cfg[0];
  wire sel0 = cfg[1];
  wire pdn0 = cfg[2];
  wire pdn1 = cfg[3];

  wire off0      = (cfg[2:0] == 3'b000);
  wire role0_pd  = pdn0 | off0;
  wire role0_oe  = !pdn0 & en0;
  wire role0_mux = !pdn0 & !en0 & sel0;

  wire pd_raw  = (role0_pd & c0) | (pdn1 & c1);
  wire pd_hold = (pd_cnt == PW'(PD_MIN));

  wire sel_tgt = role0_mux ? c0 : sel0;
  wire src0    = sel_q ? src_pre : src_mst;

  wire want0 = (st == ST_RUN) & !off0 & !(role0_oe & c0);
  wire want1 = (st == ST_RUN) & !(!pdn1 & c1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_s <= 2'b00;
      c1_s <= 2'b00;
    end else begin
      c0_s <= {c0_s[0], ctrl0};
      c1_s <= {c1_s[0], ctrl1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg <= 4'b0011;
    else if (cfg_we && st != ST_DOWN)
      cfg <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pd_cnt <= '0;
    else if (!pd_raw)
      pd_cnt <= '0;
    else if (!pd_hold)
      pd_cnt <= pd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_STAB;
      stab_cnt <= '0;
    end else begin
      case (st)
        ST_STAB: begin
          if (pd_hold) begin
            st <= ST_DOWN;
          end else if (stab_cnt == SW'(STAB_CYCLES - 1)) begin
            st <= ST_RUN;
          end else begin
            stab_cnt <= stab_cnt + 1'b1;
          end
        end
        ST_RUN:   if (pd_hold) st <= ST_DRAIN;
        ST_DRAIN: if (!oe0 && !oe1) st <= ST_DOWN;
        default: begin
          if (!pd_raw) begin
            st       <= ST_STAB;
            stab_cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      oe0   <= 1'b0;
      oe1   <= 1'b0;
    end else begin
      if (!src_mst && !src_pre) sel_q <= sel_tgt;
      if (!src0)    oe0 <= want0;
      if (!src_div) oe1 <= want1;
    end
  end

  assign out0    = oe0 & src0;
  assign out1    = oe1 & src_div;
  assign out0_oe = oe0;
  assign out1_oe = oe1;
endmodule

// File: rtl/twin_clk_gate_chk.sv
module twin_clk_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic [3:0] cfg,
  input logic       oe0,
  input logic       oe1,
  input logic       src0,
  input logic       src_mst,
  input logic       src_pre,
  input logic       src_div,
  input logic       sel_q
);
  assert_oe0_low_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe0) |-> !$past(src0));

  assert_oe1_low_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe1) |-> !$past(src_div));

  assert_down_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> (!oe0 && !oe1));

  assert_stab_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (!oe0 && !oe1));

  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |=> $stable(cfg));

  assert_mux_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> (!$past(src_mst) && !$past(src_pre)));
endmodule

bind twin_clk_gate twin_clk_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cfg(cfg), .oe0(oe0), .oe1(oe1),
  .src0(src0), .src_mst(src_mst), .src_pre(src_pre), .src_div(src_div),
  .sel_q(sel_q)
);

// File: tb/twin_clk_gate_bench.sv
`timescale 1ns/1ps
module twin_clk_gate_bench;
  localparam int STAB = 20;
  localparam int PDM  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_mst = 1'b0, src_pre = 1'b0, src_div = 1'b0;
  logic ctrl0 = 1'b0, ctrl1 = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'b0;
  logic out0, out0_oe, out1, out1_oe;

  int checks = 0, errors = 0, glitches = 0;
  int scnt = 0;
  bit done = 0;

  twin_clk_gate #(.STAB_CYCLES(STAB), .PD_MIN(PDM)) u_twin_clk_gate (
    .clk(clk), .rst_n(rst_n), .src_mst(src_mst), .src_pre(src_pre),
    .src_div(src_div), .ctrl0(ctrl0), .ctrl1(ctrl1), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .out0(out0), .out0_oe(out0_oe),
    .out1(out1), .out1_oe(out1_oe));

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    scnt++;
    src_mst = scnt[0];
    src_div = scnt[1];
    src_pre = scnt[2];
  end

  initial begin
    logic p0, p1;
    p0 = 0; p1 = 0;
    forever begin
      @(posedge clk); #1;
      if (out0_oe != p0 && out0) glitches++;
      if (out1_oe != p1 && out1) glitches++;
      if (!out0_oe && out0) glitches++;
      if (!out1_oe && out1) glitches++;
      p0 = out0_oe; p1 = out1_oe;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic follow(input bit use_pre, input string tag);
    int bad;
    bad = 0;
    repeat (16) begin
      @(posedge clk); #1;
      if (out0 != (use_pre ? src_pre : src_mst)) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int wait_n;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    // R9 reset stabilization dark
    check(!out0_oe && !out1_oe, "R9", {out0_oe, out1_oe}, 0);
    tick(40);
    // R1 defaults: out0 from prescaler, out1 enabled
    check(out0_oe && out1_oe, "R1", {out0_oe, out1_oe}, 3);
    follow(1, "R1");

    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 2; l++) begin
        bit pdr, oer, muxr, eo0, es;
        string tg;
        pdr  = c[2] || (c == 0);
        oer  = !c[2] && c[0];
        muxr = !c[2] && !c[0] && c[1];
        tg = c[2] ? "R2" : (c[0] ? "R3" : (c[1] ? "R4" : "R5"));
        ctrl0 = 1'b0; ctrl1 = 1'b0;
        wr({1'b0, 3'(c)});
        tick(40);
        ctrl0 = l[0];
        tick(40);
        if (pdr && l == 1) begin
          check(!out0_oe && !out1_oe, tg, {out0_oe, out1_oe}, 0);
          ctrl0 = 1'b0;
          tick(60);
          check(out1_oe == 1'b1, tg, out1_oe, 1);
        end else begin
          eo0 = (c != 0) && !(oer && l == 1);
          es  = muxr ? l[0] : c[1];
          check(out0_oe == eo0 && out1_oe, tg, {out0_oe, out1_oe}, {eo0, 1'b1});
          if (eo0) follow(es, tg);
        end
      end
    end

    // R6 OE role for ctrl1 touches out1 only
    ctrl0 = 1'b0; ctrl1 = 1'b0;
    wr(4'b0011);
    tick(40);
    ctrl1 = 1'b1;
    tick(20);
    check(out0_oe && !out1_oe, "R6", {out0_oe, out1_oe}, 2);
    ctrl1 = 1'b0;
    tick(20);

    // R11 short pulse rejected, R6 PD role
    wr(4'b1011);
    tick(10);
    ctrl1 = 1'b1; tick(3); ctrl1 = 1'b0;
    begin
      int drop;
      drop = 0;
      repeat (30) begin
        @(posedge clk); #1;
        if (!out0_oe || !out1_oe) drop++;
      end
      check(drop == 0, "R11", drop, 0);
    end
    ctrl1 = 1'b1;
    tick(25);
    check(!out0_oe && !out1_oe, "R6", {out0_oe, out1_oe}, 0);
    check(!out0 && !out1, "R8", {out0, out1}, 0);

    // R10 write while down ignored
    wr(4'b0000);
    tick(2);
    // R9 recovery window
    @(negedge clk); ctrl1 = 1'b0;
    wait_n = 0;
    while (!out1_oe && wait_n < 200) begin
      @(posedge clk); #1; wait_n++;
    end
    check(wait_n >= STAB && wait_n <= STAB + 12, "R9", wait_n, STAB);
    tick(10);
    check(out0_oe == 1'b1, "R10", out0_oe, 1);
    ctrl1 = 1'b1;
    tick(25);
    check(!out0_oe && !out1_oe, "R10", {out0_oe, out1_oe}, 0);
    ctrl1 = 1'b0;
    tick(60);

    // R7 no truncated pulse or driven-while-off sample anywhere
    check(glitches == 0, "R7", glitches, 0);
    finish_run();
  end
endmodule